// File: doc/BRIEF.md
# Frame-Indexed Translation Search Unit

This block turns a (process identifier, virtual page) key into a physical frame number by means of a table with exactly one record per physical frame. The record for frame f lives at position f. It holds the owning process identifier, the virtual page number and a valid flag. No record carries a frame number. The frame returned by a translation is the position of the record that matches the key, so a translation is a search over every frame position.

The table is held in flip-flops inside the block. A write port loads or clears the record at a chosen frame position. A lookup port accepts a key and scans one record per clock, from position 0 upward, and stops at the first match. The result is a one-cycle `res_done` pulse with `res_hit` and `res_frame`. The search time grows with the position of the match, and a miss costs one cycle per frame. While a search runs, both ports deassert their ready signals, so the table cannot change under the scan.

Top module: `ipt_search_unit`

## Requirements
- R1: Synchronous reset clears the valid flag of every record and leaves both `lk_ready` and `wr_ready` at 1 and `res_done` at 0. A lookup after reset misses.
- R2: A write accepted with `wr_set`=1 stores `wr_pid` and `wr_page` at record `wr_frame` and marks it valid. A write accepted with `wr_set`=0 clears the valid flag of record `wr_frame`, so that record never matches again until it is rewritten.
- R3: A hit returns `res_hit`=1 and `res_frame` equal to the lowest record position whose valid flag is 1 and whose stored identifier and page both equal the key. A record that matches only one of the two fields does not hit.
- R4: When the first match is at position i, `res_done` is high in the cycle after the (i+1)-th rising edge that follows the accepting edge. Every lookup completes within FRAMES edges.
- R5: When no valid record matches, `res_done` rises FRAMES edges after the accepting edge, with `res_hit`=0 and `res_frame`=0.
- R6: From the edge after a lookup is accepted until its result, `lk_ready` and `wr_ready` are both 0. Both are 1 again in the cycle in which `res_done` is 1.
- R7: `lk_valid` and `wr_valid` presented while the ready signals are 0 are ignored. They change neither the result of the running search nor the table.
- R8: A write and a lookup accepted at the same edge are both taken. The search sees the newly written record.
- R9: `res_done` is a single-cycle pulse. While it is 0, `res_hit` and `res_frame` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | PID_W | Process identifier of the key |
| lk_page | input | PAGE_W | Virtual page of the key |
| lk_ready | output | 1 | Lookup port can accept a request |
| res_done | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Key found (valid with res_done) |
| res_frame | output | IDX_W | Frame number of the match (valid with res_done) |
| wr_valid | input | 1 | Record write request |
| wr_ready | output | 1 | Write port can accept a request |
| wr_frame | input | IDX_W | Record position (frame number) to write |
| wr_set | input | 1 | 1 loads and validates the record, 0 invalidates it |
| wr_pid | input | PID_W | Process identifier to store |
| wr_page | input | PAGE_W | Virtual page to store |

## Verification
A corrupted record or a lost valid flag shows up only at the first lookup that reaches that position. It appears as a wrong frame, a false miss, or a result at the wrong cycle, because the completion time depends on the match position. A scan index that skips or stalls moves the `res_done` edge, and the per-clock reference model catches this in the very cycle the pulse is early or late. A ready signal that does not drop during a scan lets a write slip in. That error surfaces at the following lookup of the held-off key.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int DEF_FRAMES = 64;
    localparam int DEF_PID_W  = 8;
    localparam int DEF_PAGE_W = 20;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ipt_store.sv
module ipt_store #(
    parameter int FRAMES = 64,
    parameter int PID_W  = 8,
    parameter int PAGE_W = 20,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              wset,
    input  logic [IDX_W-1:0]  widx,
    input  logic [PID_W-1:0]  wpid,
    input  logic [PAGE_W-1:0] wpage,
    input  logic [IDX_W-1:0]  ridx,
    output logic              rvld,
    output logic [PID_W-1:0]  rpid,
    output logic [PAGE_W-1:0] rpage
);

    typedef struct packed {
        logic              vld;
        logic [PID_W-1:0]  pid;
        logic [PAGE_W-1:0] page;
    } rec_t;

    rec_t tbl [FRAMES];
    rec_t rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FRAMES; i++) begin
                tbl[i].vld <= 1'b0;
            end
        end else if (we) begin
            for (int i = 0; i < FRAMES; i++) begin
                if (widx == IDX_W'(i)) begin
                    tbl[i].vld <= wset;
                    if (wset) begin
                        tbl[i].pid  <= wpid;
                        tbl[i].page <= wpage;
                    end
                end
            end
        end
    end

    always_comb begin
        rd    = tbl[ridx];
        rvld  = rd.vld;
        rpid  = rd.pid;
        rpage = rd.page;
    end

endmodule

// File: rtl/ipt_key_cmp.sv
module ipt_key_cmp #(
    parameter int PID_W  = 8,
    parameter int PAGE_W = 20
) (
    input  logic              rec_vld,
    input  logic [PID_W-1:0]  rec_pid,
    input  logic [PAGE_W-1:0] rec_page,
    input  logic [PID_W-1:0]  key_pid,
    input  logic [PAGE_W-1:0] key_page,
    output logic              match
);

    logic pid_eq;
    logic page_eq;

    always_comb begin
        pid_eq  = (rec_pid == key_pid);
        page_eq = (rec_page == key_page);
        match   = rec_vld && pid_eq && page_eq;
    end

endmodule

// File: rtl/ipt_scan.sv
module ipt_scan
    import ipt_pkg::*;
#(
    parameter int FRAMES = 64,
    parameter int PID_W  = 8,
    parameter int PAGE_W = 20,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PID_W-1:0]  start_pid,
    input  logic [PAGE_W-1:0] start_page,
    input  logic              match_now,
    output logic              idle,
    output logic [PID_W-1:0]  key_pid,
    output logic [PAGE_W-1:0] key_page,
    output logic [IDX_W-1:0]  idx,
    output logic              res_done,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_frame
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [PAGE_W-1:0] page;
    } key_t;

    scan_st_e st;
    key_t     key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            key_q     <= '0;
            idx       <= '0;
            res_done  <= 1'b0;
            res_hit   <= 1'b0;
            res_frame <= '0;
        end else begin
            res_done  <= 1'b0;
            res_hit   <= 1'b0;
            res_frame <= '0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        key_q.pid  <= start_pid;
                        key_q.page <= start_page;
                        idx        <= '0;
                        st         <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (match_now) begin
                        res_done  <= 1'b1;
                        res_hit   <= 1'b1;
                        res_frame <= idx;
                        st        <= ST_IDLE;
                    end else if (idx == LAST) begin
                        res_done <= 1'b1;
                        st       <= ST_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle     = (st == ST_IDLE);
        key_pid  = key_q.pid;
        key_page = key_q.page;
    end

endmodule

// File: rtl/ipt_search_unit.sv
module ipt_search_unit
    import ipt_pkg::*;
#(
    parameter  int FRAMES = DEF_FRAMES,
    parameter  int PID_W  = DEF_PID_W,
    parameter  int PAGE_W = DEF_PAGE_W,
    localparam int IDX_W  = idx_width(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_ready,
    output logic              res_done,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_frame,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [IDX_W-1:0]  wr_frame,
    input  logic              wr_set,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [PAGE_W-1:0] wr_page
);

    logic              idle;
    logic [IDX_W-1:0]  scan_idx;
    logic [PID_W-1:0]  key_pid;
    logic [PAGE_W-1:0] key_page;
    logic              rec_vld;
    logic [PID_W-1:0]  rec_pid;
    logic [PAGE_W-1:0] rec_page;
    logic              match_now;
    logic              wr_take;
    logic              lk_take;

    always_comb begin
        lk_ready = idle;
        wr_ready = idle;
        wr_take  = wr_valid && idle;
        lk_take  = lk_valid && idle;
    end

    ipt_store #(
        .FRAMES(FRAMES), .PID_W(PID_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_take),
        .wset  (wr_set),
        .widx  (wr_frame),
        .wpid  (wr_pid),
        .wpage (wr_page),
        .ridx  (scan_idx),
        .rvld  (rec_vld),
        .rpid  (rec_pid),
        .rpage (rec_page)
    );

    ipt_key_cmp #(
        .PID_W(PID_W), .PAGE_W(PAGE_W)
    ) u_cmp (
        .rec_vld  (rec_vld),
        .rec_pid  (rec_pid),
        .rec_page (rec_page),
        .key_pid  (key_pid),
        .key_page (key_page),
        .match    (match_now)
    );

    ipt_scan #(
        .FRAMES(FRAMES), .PID_W(PID_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_scan (
        .clk        (clk),
        .rst        (rst),
        .start      (lk_take),
        .start_pid  (lk_pid),
        .start_page (lk_page),
        .match_now  (match_now),
        .idle       (idle),
        .key_pid    (key_pid),
        .key_page   (key_page),
        .idx        (scan_idx),
        .res_done   (res_done),
        .res_hit    (res_hit),
        .res_frame  (res_frame)
    );

endmodule

// File: rtl/ipt_search_chk.sv
module ipt_search_chk #(
    parameter int FRAMES = 64,
    parameter int IDX_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             wr_ready,
    input logic             res_done,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_frame
);

    localparam int CNT_W = IDX_W + 2;

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (lk_ready) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);                                          // R9

    AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (rst)
        !res_done |-> (!res_hit && res_frame == '0));                     // R9

    AST_MISS_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_done && !res_hit) |-> (res_frame == '0));                    // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> (!lk_ready && !wr_ready));             // R6

    AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        res_done |-> (lk_ready && wr_ready));                             // R6

    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= CNT_W'(FRAMES));                                      // R4

endmodule

bind ipt_search_unit ipt_search_chk #(
    .FRAMES(FRAMES), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .wr_ready  (wr_ready),
    .res_done  (res_done),
    .res_hit   (res_hit),
    .res_frame (res_frame)
);

// File: tb/tb_ipt_search_unit.sv
module tb_ipt_search_unit;

    localparam int FRAMES = 64;
    localparam int PID_W  = 8;
    localparam int PAGE_W = 20;
    localparam int IDX_W  = ipt_pkg::idx_width(FRAMES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [PID_W-1:0]  lk_pid = '0;
    logic [PAGE_W-1:0] lk_page = '0;
    logic              lk_ready;
    logic              res_done;
    logic              res_hit;
    logic [IDX_W-1:0]  res_frame;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [IDX_W-1:0]  wr_frame = '0;
    logic              wr_set = 1'b0;
    logic [PID_W-1:0]  wr_pid = '0;
    logic [PAGE_W-1:0] wr_page = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    bit              mv [FRAMES];
    int              mp [FRAMES];
    int              mg [FRAMES];
    bit              busy = 1'b0;
    int              cnt = 0;
    bit              p_hit = 1'b0;
    int              p_frame = 0;
    bit              e_done = 1'b0;
    bit              e_hit = 1'b0;
    int              e_frame = 0;

    always #4 clk = ~clk;

    ipt_search_unit #(.FRAMES(FRAMES), .PID_W(PID_W), .PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_page(lk_page), .lk_ready(lk_ready),
        .res_done(res_done), .res_hit(res_hit), .res_frame(res_frame),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_frame(wr_frame), .wr_set(wr_set),
        .wr_pid(wr_pid), .wr_page(wr_page)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < FRAMES; f++) mv[f] = 1'b0;
            busy = 1'b0; cnt = 0;
            e_done = 1'b0; e_hit = 1'b0; e_frame = 0;
        end else begin
            bit was_busy;
            was_busy = busy;
            e_done = 1'b0; e_hit = 1'b0; e_frame = 0;
            if (busy) begin
                cnt--;
                if (cnt == 0) begin
                    e_done = 1'b1; e_hit = p_hit; e_frame = p_frame; busy = 1'b0;
                end
            end
            if (!was_busy && wr_valid) begin
                if (wr_set) begin
                    mv[wr_frame] = 1'b1; mp[wr_frame] = int'(wr_pid); mg[wr_frame] = int'(wr_page);
                end else begin
                    mv[wr_frame] = 1'b0;
                end
            end
            if (!was_busy && lk_valid) begin
                p_hit = 1'b0; p_frame = 0; cnt = FRAMES;
                for (int f = FRAMES - 1; f >= 0; f--) begin
                    if (mv[f] && mp[f] == int'(lk_pid) && mg[f] == int'(lk_page)) begin
                        p_hit = 1'b1; p_frame = f; cnt = f + 1;
                    end
                end
                busy = 1'b1;
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (model_on && !finished) begin
            chk(res_done == e_done, "R4 model res_done", res_done, e_done);
            chk(res_hit == e_hit, "R3 model res_hit", res_hit, e_hit);
            chk(int'(res_frame) == e_frame, "R3 model res_frame", res_frame, e_frame);
            chk(lk_ready == !busy, "R6 model lk_ready", lk_ready, !busy);
            chk(wr_ready == !busy, "R6 model wr_ready", wr_ready, !busy);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic do_write(input int f, input bit set, input int p, input int g);
        @(negedge clk);
        wr_valid = 1'b1; wr_frame = IDX_W'(f); wr_set = set;
        wr_pid = PID_W'(p); wr_page = PAGE_W'(g);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // lookup with optional same-edge write; elat < 0 skips directed checks
    task automatic lookup(input int p, input int g, input bit eh, input int ef, input int elat,
                          input string tag, input bit with_wr, input int wf, input int wp, input int wg);
        int n;
        n = 0;
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = PID_W'(p); lk_page = PAGE_W'(g);
        if (with_wr) begin
            wr_valid = 1'b1; wr_frame = IDX_W'(wf); wr_set = 1'b1;
            wr_pid = PID_W'(wp); wr_page = PAGE_W'(wg);
        end
        do begin
            @(negedge clk);
            n++;
            lk_valid = 1'b0;
            wr_valid = 1'b0;
        end while (!res_done && n < FRAMES + 8);
        if (elat >= 0) begin
            chk(res_done == 1'b1, {tag, " done seen"}, res_done, 1);
            chk(res_hit == eh, {tag, " hit"}, res_hit, eh);
            chk(int'(res_frame) == ef, {tag, " frame"}, res_frame, ef);
            chk(n - 1 == elat, "R4 latency in edges", n - 1, elat);
        end
        @(negedge clk);
        chk(!res_done && !res_hit && res_frame == '0, "R9 quiet after pulse", {res_done, res_hit}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_on = 1'b1;
        chk(lk_ready == 1'b1, "R1 lk_ready after reset", lk_ready, 1);
        chk(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
        chk(res_done == 1'b0, "R1 res_done after reset", res_done, 0);

        // empty table misses after a full scan
        lookup(0, 0, 1'b0, 0, FRAMES, "R1 R5 empty miss", 1'b0, 0, 0, 0);

        do_write(5, 1'b1, 3, 'h100);
        do_write(0, 1'b1, 1, 'h42);
        do_write(FRAMES - 1, 1'b1, 7, 'hABCDE);
        lookup(3, 'h100, 1'b1, 5, 6, "R2 R3 frame 5", 1'b0, 0, 0, 0);
        lookup(1, 'h42, 1'b1, 0, 1, "R3 frame 0", 1'b0, 0, 0, 0);
        lookup(7, 'hABCDE, 1'b1, FRAMES - 1, FRAMES, "R3 last frame", 1'b0, 0, 0, 0);

        // one field matching is not enough
        lookup(3, 'h101, 1'b0, 0, FRAMES, "R3 R5 page differs", 1'b0, 0, 0, 0);
        lookup(4, 'h100, 1'b0, 0, FRAMES, "R3 R5 pid differs", 1'b0, 0, 0, 0);

        // duplicate key: lowest position wins, then invalidation exposes the next
        do_write(40, 1'b1, 9, 'h777);
        do_write(10, 1'b1, 9, 'h777);
        lookup(9, 'h777, 1'b1, 10, 11, "R3 lowest of duplicates", 1'b0, 0, 0, 0);
        do_write(10, 1'b0, 0, 0);
        lookup(9, 'h777, 1'b1, 40, 41, "R2 cleared record skipped", 1'b0, 0, 0, 0);

        // requests while busy are ignored
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = PID_W'(9); lk_page = PAGE_W'('h777);
        @(negedge clk);
        lk_pid = PID_W'(1); lk_page = PAGE_W'('h42);
        wr_valid = 1'b1; wr_frame = IDX_W'(20); wr_set = 1'b1;
        wr_pid = PID_W'(12); wr_page = PAGE_W'('h12);
        chk(wr_ready == 1'b0, "R6 wr_ready low while scanning", wr_ready, 0);
        chk(lk_ready == 1'b0, "R6 lk_ready low while scanning", lk_ready, 0);
        repeat (5) @(negedge clk);
        lk_valid = 1'b0; wr_valid = 1'b0;
        while (!res_done) @(negedge clk);
        chk(res_hit == 1'b1 && res_frame == IDX_W'(40), "R7 running search kept its key", res_frame, 40);
        chk(lk_ready == 1'b1, "R6 ready with done", lk_ready, 1);
        lookup(12, 'h12, 1'b0, 0, FRAMES, "R7 held-off write not stored", 1'b0, 0, 0, 0);

        // same-edge write and lookup
        lookup(5, 'h55, 1'b1, 2, 3, "R8 same-edge write seen", 1'b1, 2, 5, 'h55);

        // mixed traffic against the reference model
        for (int k = 0; k < 80; k++) begin
            int f, p, g;
            f = int'($urandom_range(FRAMES - 1, 0));
            p = int'($urandom_range(3, 0));
            g = int'($urandom_range(3, 0));
            if ($urandom_range(1, 0) == 0) do_write(f, ($urandom_range(3, 0) != 0), p, g);
            else lookup(p, g, 1'b0, 0, -1, "R3 R5 random", 1'b0, 0, 0, 0);
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule